// File: doc/BRIEF.md
# Dual Wiper Command Executor

This block sits behind a two-wire serial slave front end and carries out the commands that address a pair of 6-bit wiper channels. Each channel has one volatile wiper position and four retained data registers, which hold stored positions. The front end reports bus events to the executor as single-cycle strobes: a start with a matched address, each received byte, each stop, and each step clock while an increment/decrement command is active. The executor returns an acknowledge decision for each byte and a read value. It also reports when it is in step mode and when it is busy.

The retained registers are modelled as flip-flops. Any change to them starts a busy window whose length is a parameter in system-clock cycles, and this window stands in for the nonvolatile write time. While the window is open the executor ignores the bus. An active-low write-protect input suppresses stores. A protected store is still acknowledged, but it changes nothing and does not start the busy window. After reset, each wiper is loaded from data register 0 of its own channel.

Top module: `dualPotExec`

## Requirements
- R1: After reset, data register n of channel c holds INIT_CHc + n (modulo 64). One cycle after reset is released, each wiper equals data register 0 of its own channel. busy and rdValid are low.
- R2: The instruction byte carries the opcode in bits 7:4, the register index in bits 3:2, a bit 1 that must be 0, and the channel in bit 0. Nine opcodes are valid: 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. Any other opcode, or bit 1 set, gives ackOut low. Such a command is then discarded, and it still has no effect after the following stop.
- R3: Write-wiper (1010) takes a data byte. Bits 5:0 of that byte become the selected wiper at the stop, and bits 7:6 are ignored. The wiper does not change before the stop.
- R4: Read-wiper (1001) and read-data-register (1011) raise rdValid. They present {2'b00, value} on rdData one cycle after the instruction byte strobe.
- R5: Transfer data-register-to-wiper (1101) copies the indexed data register of the selected channel into that channel's wiper at the stop. The other channel is unaffected.
- R6: Write-data-register (1100, with a data byte) and transfer wiper-to-data-register (1110) update the indexed register at the stop. busy then stays high for exactly BUSY_CYCLES cycles.
- R7: Global transfers 0001 (data register to wiper) and 1000 (wiper to data register) apply the same register index to both channels at once. 1000 is a store, and it opens the busy window.
- R8: When wpN is low at the stop, a store is acknowledged but leaves every data register unchanged and does not raise busy.
- R9: While busy is high, start, byte, step and stop strobes have no effect, and ackOut stays low.
- R10: After the increment/decrement opcode (0010), stepMode is high. Each step strobe moves the selected wiper by one, up when stepUp is 1 and down otherwise, saturating at 63 and at 0. The other channel is unaffected.
- R11: A command commits only on a stop that follows the complete command. A new start before the stop discards it. An extra byte after a complete command is not acknowledged and discards the command.
- R12: ackOut holds the acknowledge decision for the most recent byte, from one cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wpN | input | 1 | Write-protect, low blocks stores |
| startStb | input | 1 | Start with address match |
| stopStb | input | 1 | Stop condition seen |
| byteStb | input | 1 | A byte was received |
| byteIn | input | 8 | Received byte |
| stepStb | input | 1 | One step clock in step mode |
| stepUp | input | 1 | Step direction, 1 = up |
| ackOut | output | 1 | Acknowledge decision for the last byte |
| rdValid | output | 1 | Read data available |
| rdData | output | 8 | Read value, two leading zeros |
| stepMode | output | 1 | Increment/decrement mode active |
| busy | output | 1 | Emulated store in progress |
| wiper0 | output | 6 | Channel 0 wiper position |
| wiper1 | output | 6 | Channel 1 wiper position |

## Verification
The hardest case to reach from the ports is the bus traffic that arrives inside the busy window. The stimulus reaches it by issuing a store with the busy length shortened to 16 cycles. During that window it sends a complete write-wiper command, including its stop. The bench then waits for busy to fall and checks that the wiper did not move. Saturation of the step counter is reached by first writing 63 into a wiper and then stepping up, and the protected store is confirmed by reading the target register back.

// File: rtl/potCmdPkg.sv
package potCmdPkg;
  localparam int POS_W = 6;
  localparam int CH_N  = 2;
  localparam int REG_N = 4;
  localparam int IDX_W = $clog2(REG_N);

  localparam logic [3:0] OP_RD_WIP = 4'b1001;
  localparam logic [3:0] OP_WR_WIP = 4'b1010;
  localparam logic [3:0] OP_RD_DR  = 4'b1011;
  localparam logic [3:0] OP_WR_DR  = 4'b1100;
  localparam logic [3:0] OP_DR2W   = 4'b1101;
  localparam logic [3:0] OP_W2DR   = 4'b1110;
  localparam logic [3:0] OP_G_DR2W = 4'b0001;
  localparam logic [3:0] OP_G_W2DR = 4'b1000;
  localparam logic [3:0] OP_STEP   = 4'b0010;

  // strobes from control to datapath
  typedef struct packed {
    logic              recall;
    logic [CH_N-1:0]   wipLoad;
    logic              wipFromDr;
    logic [CH_N-1:0]   drStore;
    logic              drFromWip;
    logic [IDX_W-1:0]  idx;
    logic [POS_W-1:0]  hostVal;
    logic              step;
    logic              stepCh;
    logic              stepUp;
  } ctl_t;
endpackage

// File: rtl/potDatapath.sv
module potDatapath
  import potCmdPkg::*;
#(
  parameter logic [CH_N-1:0][POS_W-1:0] INIT_VALS = '0
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctl_t                               ctl,
  output logic [CH_N-1:0][POS_W-1:0]         wiperQ,
  output logic [CH_N-1:0][REG_N-1:0][POS_W-1:0] drQ
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] wipMem [CH_N];
  logic [POS_W-1:0] drMem  [CH_N][REG_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic stepHere;
    assign stepHere = ctl.step && (ctl.stepCh == 1'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wipMem[c] <= '0;
      end else if (ctl.recall) begin
        wipMem[c] <= drMem[c][0];
      end else if (ctl.wipLoad[c]) begin
        wipMem[c] <= ctl.wipFromDr ? drMem[c][ctl.idx] : ctl.hostVal;
      end else if (stepHere) begin
        if (ctl.stepUp) begin
          if (wipMem[c] != POS_MAX) wipMem[c] <= wipMem[c] + 1'b1;
        end else begin
          if (wipMem[c] != '0) wipMem[c] <= wipMem[c] - 1'b1;
        end
      end
    end
    assign wiperQ[c] = wipMem[c];

    for (genvar r = 0; r < REG_N; r++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          drMem[c][r] <= INIT_VALS[c] + POS_W'(r);
        else if (ctl.drStore[c] && (ctl.idx == IDX_W'(r)))
          drMem[c][r] <= ctl.drFromWip ? wipMem[c] : ctl.hostVal;
      end
      assign drQ[c][r] = drMem[c][r];
    end

    // registers of a channel move only when a store strobe names that channel
    assert_dr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.drStore[c] |=> $stable(drQ[c]));

    // an upward step from the top end leaves the wiper at the top end
    assert_step_sat_R10: assert property (@(posedge clk) disable iff (!rstN)
      (stepHere && ctl.stepUp && !ctl.recall && !ctl.wipLoad[c] && wiperQ[c] == POS_MAX)
        |=> wiperQ[c] == POS_MAX);

    // a downward step from zero leaves the wiper at zero
    assert_step_floor_R10: assert property (@(posedge clk) disable iff (!rstN)
      (stepHere && !ctl.stepUp && !ctl.recall && !ctl.wipLoad[c] && wiperQ[c] == '0)
        |=> wiperQ[c] == '0);
  end
endmodule

// File: rtl/potControl.sv
module potControl
  import potCmdPkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  wpN,
  input  logic                                  startStb,
  input  logic                                  stopStb,
  input  logic                                  byteStb,
  input  logic [7:0]                            byteIn,
  input  logic                                  stepStb,
  input  logic                                  stepUp,
  input  logic [CH_N-1:0][POS_W-1:0]            wiperQ,
  input  logic [CH_N-1:0][REG_N-1:0][POS_W-1:0] drQ,
  output ctl_t                                  ctl,
  output logic                                  ackOut,
  output logic                                  rdValid,
  output logic [7:0]                            rdData,
  output logic                                  stepMode,
  output logic                                  busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [3:0] {
    S_RECALL, S_IDLE, S_CMD, S_DATA, S_ARMED, S_READ, S_STEP, S_BUSY, S_DEAD
  } state_t;

  state_t            state;
  logic [3:0]        opReg;
  logic              chReg;
  logic [IDX_W-1:0]  idxReg;
  logic [POS_W-1:0]  hostReg;
  logic [POS_W-1:0]  rdReg;
  logic              ackReg;
  logic [CNT_W-1:0]  busyCnt;

  logic [3:0]        opIn;
  logic              chIn;
  logic [IDX_W-1:0]  idxIn;
  logic              opKnown;
  logic              cmdOk;
  logic [POS_W-1:0]  rdPick;
  logic              storeGo;

  assign opIn  = byteIn[7:4];
  assign chIn  = byteIn[0];
  assign idxIn = byteIn[3:2];

  always_comb begin
    case (opIn)
      OP_RD_WIP, OP_WR_WIP, OP_RD_DR, OP_WR_DR, OP_DR2W,
      OP_W2DR, OP_G_DR2W, OP_G_W2DR, OP_STEP: opKnown = 1'b1;
      default:                                opKnown = 1'b0;
    endcase
    cmdOk  = opKnown && !byteIn[1];
    rdPick = (opIn == OP_RD_WIP) ? wiperQ[chIn] : drQ[chIn][idxIn];
  end

  // strobe generation
  always_comb begin
    ctl         = '0;
    ctl.idx     = idxReg;
    ctl.hostVal = hostReg;
    ctl.stepCh  = chReg;
    ctl.stepUp  = stepUp;
    if (state == S_RECALL) ctl.recall = 1'b1;
    if (state == S_ARMED && stopStb && !startStb) begin
      case (opReg)
        OP_WR_WIP: ctl.wipLoad[chReg] = 1'b1;
        OP_DR2W: begin
          ctl.wipLoad[chReg] = 1'b1;
          ctl.wipFromDr      = 1'b1;
        end
        OP_G_DR2W: begin
          ctl.wipLoad   = '1;
          ctl.wipFromDr = 1'b1;
        end
        OP_WR_DR:  if (wpN) ctl.drStore[chReg] = 1'b1;
        OP_W2DR: begin
          if (wpN) ctl.drStore[chReg] = 1'b1;
          ctl.drFromWip = 1'b1;
        end
        OP_G_W2DR: begin
          if (wpN) ctl.drStore = '1;
          ctl.drFromWip = 1'b1;
        end
        default: ;
      endcase
    end
    if (state == S_STEP && stepStb && !startStb && !stopStb) ctl.step = 1'b1;
  end

  assign storeGo = |ctl.drStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_RECALL;
      opReg   <= '0;
      chReg   <= 1'b0;
      idxReg  <= '0;
      hostReg <= '0;
      rdReg   <= '0;
      ackReg  <= 1'b0;
      busyCnt <= '0;
    end else if (state == S_RECALL) begin
      state <= S_IDLE;
    end else if (state == S_BUSY) begin
      if (busyCnt == '0) state <= S_IDLE;
      else               busyCnt <= busyCnt - 1'b1;
    end else if (startStb) begin
      state <= S_CMD;
    end else if (stopStb) begin
      if (storeGo) begin
        state   <= S_BUSY;
        busyCnt <= CNT_W'(BUSY_CYCLES - 1);
        ackReg  <= 1'b0;
      end else begin
        state <= S_IDLE;
      end
    end else if (byteStb) begin
      case (state)
        S_CMD: begin
          if (cmdOk) begin
            ackReg <= 1'b1;
            opReg  <= opIn;
            chReg  <= chIn;
            idxReg <= idxIn;
            case (opIn)
              OP_RD_WIP, OP_RD_DR: begin
                state <= S_READ;
                rdReg <= rdPick;
              end
              OP_WR_WIP, OP_WR_DR: state <= S_DATA;
              OP_STEP:             state <= S_STEP;
              default:             state <= S_ARMED;
            endcase
          end else begin
            ackReg <= 1'b0;
            state  <= S_DEAD;
          end
        end
        S_DATA: begin
          ackReg  <= 1'b1;
          hostReg <= byteIn[POS_W-1:0];
          state   <= S_ARMED;
        end
        S_IDLE: ackReg <= 1'b0;
        default: begin
          ackReg <= 1'b0;
          state  <= S_DEAD;
        end
      endcase
    end
  end

  assign ackOut   = ackReg;
  assign rdValid  = (state == S_READ);
  assign rdData   = {2'b00, rdReg};
  assign stepMode = (state == S_STEP);
  assign busy     = (state == S_BUSY);

  // a busy window only opens from an unprotected store
  assert_busy_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wpN) && $past(stopStb));

  // nothing reaches the datapath while the store window is open
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (ctl.wipLoad == '0 && ctl.drStore == '0 && !ctl.step));

  // acknowledge stays low across the busy window
  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !ackOut);

  // read, step and busy modes never overlap
  assert_modes_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, rdValid, stepMode}));
endmodule

// File: rtl/dualPotExec.sv
module dualPotExec
  import potCmdPkg::*;
#(
  parameter int               BUSY_CYCLES = 500000,
  parameter logic [POS_W-1:0] INIT_CH0    = 6'd21,
  parameter logic [POS_W-1:0] INIT_CH1    = 6'd42
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpN,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic       byteStb,
  input  logic [7:0] byteIn,
  input  logic       stepStb,
  input  logic       stepUp,
  output logic       ackOut,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       stepMode,
  output logic       busy,
  output logic [5:0] wiper0,
  output logic [5:0] wiper1
);
  ctl_t                                  ctl;
  logic [CH_N-1:0][POS_W-1:0]            wiperQ;
  logic [CH_N-1:0][REG_N-1:0][POS_W-1:0] drQ;

  potControl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .wpN(wpN),
    .startStb(startStb), .stopStb(stopStb),
    .byteStb(byteStb), .byteIn(byteIn),
    .stepStb(stepStb), .stepUp(stepUp),
    .wiperQ(wiperQ), .drQ(drQ), .ctl(ctl),
    .ackOut(ackOut), .rdValid(rdValid), .rdData(rdData),
    .stepMode(stepMode), .busy(busy)
  );

  potDatapath #(.INIT_VALS({INIT_CH1, INIT_CH0})) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wiperQ(wiperQ), .drQ(drQ)
  );

  assign wiper0 = wiperQ[0];
  assign wiper1 = wiperQ[1];
endmodule

// File: tb/sim_dualPotExec.sv
module sim_dualPotExec;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wpN = 1'b1;
  logic       startStb = 1'b0, stopStb = 1'b0, byteStb = 1'b0;
  logic [7:0] byteIn = '0;
  logic       stepStb = 1'b0, stepUp = 1'b0;
  logic       ackOut, rdValid, stepMode, busy;
  logic [7:0] rdData;
  logic [5:0] wiper0, wiper1;

  int vectors = 0;
  int errors  = 0;

  typedef struct {
    int    sel;
    int    exp;
    string tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  dualPotExec #(.BUSY_CYCLES(16), .INIT_CH0(6'd21), .INIT_CH1(6'd42)) u0 (
    .clk(clk), .rstN(rstN), .wpN(wpN),
    .startStb(startStb), .stopStb(stopStb),
    .byteStb(byteStb), .byteIn(byteIn),
    .stepStb(stepStb), .stepUp(stepUp),
    .ackOut(ackOut), .rdValid(rdValid), .rdData(rdData),
    .stepMode(stepMode), .busy(busy),
    .wiper0(wiper0), .wiper1(wiper1)
  );

  function automatic int probe(int sel);
    case (sel)
      0: return int'(wiper0);
      1: return int'(wiper1);
      2: return int'(rdData);
      3: return int'(ackOut);
      4: return int'(busy);
      5: return int'(rdValid);
      default: return int'(stepMode);
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(probe(it.sel), it.exp, it.tag);
      end
    end
  end

  task automatic expectOut(int sel, int exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic doStart();
    @(negedge clk) startStb = 1'b1;
    @(negedge clk) startStb = 1'b0;
  endtask
  task automatic doStop();
    @(negedge clk) stopStb = 1'b1;
    @(negedge clk) stopStb = 1'b0;
  endtask
  task automatic doByte(logic [7:0] b);
    @(negedge clk) begin byteIn = b; byteStb = 1'b1; end
    @(negedge clk) byteStb = 1'b0;
  endtask
  task automatic doStep(logic up);
    @(negedge clk) begin stepUp = up; stepStb = 1'b1; end
    @(negedge clk) stepStb = 1'b0;
  endtask
  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readDr(logic ch, logic [1:0] idx, int exp, string tag);
    doStart();
    doByte({4'b1011, idx, 1'b0, ch});
    expectOut(2, exp, tag);
    doStop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: recall of register 0 into each wiper
    expectOut(0, 21, "R1 wiper0 after recall");
    expectOut(1, 42, "R1 wiper1 after recall");
    expectOut(4, 0,  "R1 busy low");
    expectOut(5, 0,  "R1 rdValid low");

    // R4, R12: read wiper of channel 1
    doStart();
    doByte(8'h91);
    expectOut(3, 1,  "R12 ack on read instruction");
    expectOut(5, 1,  "R4 rdValid");
    expectOut(2, 42, "R4 read wiper1");
    doStop();
    readDr(1'b0, 2'd2, 23, "R4 read dr ch0 idx2");

    // R3, R11: write wiper 0 with high bits set
    doStart();
    doByte(8'hA0);
    doByte(8'hFF);
    expectOut(0, 21, "R11 wiper0 unchanged before stop");
    doStop();
    expectOut(0, 63, "R3 wiper0 written at stop");

    // R10: stepping with saturation
    doStart();
    doByte(8'h20);
    expectOut(6, 1, "R10 stepMode");
    doStep(1'b1);
    doStep(1'b1);
    expectOut(0, 63, "R10 saturate at 63");
    doStep(1'b0);
    doStep(1'b0);
    doStep(1'b0);
    expectOut(0, 60, "R10 step down three");
    expectOut(1, 42, "R10 other channel still");
    doStop();

    // R5: data register to wiper, channel 1 idx3
    doStart();
    doByte(8'hDD);
    doStop();
    expectOut(1, 45, "R5 transfer ch1 idx3");
    expectOut(0, 60, "R5 ch0 untouched");

    // R6: write data register ch0 idx1 and busy length
    doStart();
    doByte(8'hC4);
    doByte(8'h05);
    doStop();
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt, 16, "R6 busy length");
    @(negedge clk);
    readDr(1'b0, 2'd1, 5, "R6 stored value");

    // R9: traffic during busy is ignored
    doStart();
    doByte(8'hE1);
    doStop();
    doStart();
    doByte(8'hA0);
    expectOut(3, 0, "R9 nack while busy");
    doByte(8'h01);
    doStop();
    waitIdle();
    expectOut(0, 60, "R9 wiper0 unchanged after busy");
    readDr(1'b1, 2'd0, 45, "R6 wiper-to-register ch1");

    // R7: global transfers
    doStart();
    doByte(8'h14);
    doStop();
    expectOut(0, 5,  "R7 global load ch0");
    expectOut(1, 43, "R7 global load ch1");
    doStart();
    doByte(8'h8C);
    doStop();
    expectOut(4, 1, "R7 global store busy");
    waitIdle();
    readDr(1'b0, 2'd3, 5,  "R7 global store ch0");
    readDr(1'b1, 2'd3, 43, "R7 global store ch1");

    // R8: protected store
    wpN = 1'b0;
    doStart();
    doByte(8'hC8);
    expectOut(3, 1, "R8 ack instruction");
    doByte(8'h09);
    expectOut(3, 1, "R8 ack data");
    doStop();
    expectOut(4, 0, "R8 no busy");
    wpN = 1'b1;
    readDr(1'b0, 2'd2, 23, "R8 register unchanged");

    // R2: rejected instructions
    doStart();
    doByte(8'h30);
    expectOut(3, 0, "R2 unknown opcode nack");
    doStop();
    doStart();
    doByte(8'h92);
    expectOut(3, 0, "R2 bit1 set nack");
    doStop();
    doStart();
    doByte(8'hA6);
    doByte(8'h11);
    doStop();
    expectOut(0, 5, "R2 bit1 write discarded");
    expectOut(4, 0, "R2 no busy after reject");

    // R11: repeated start and extra byte discard
    doStart();
    doByte(8'hA1);
    doByte(8'h07);
    doStart();
    doStop();
    expectOut(1, 43, "R11 restart discards");
    doStart();
    doByte(8'hD0);
    doByte(8'h00);
    expectOut(3, 0, "R11 extra byte nack");
    doStop();
    expectOut(0, 5, "R11 extra byte discards");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule